// File: doc/BRIEF.md
# Direct-Mapped Write-Through Word Cache

This block sits between a processor request port and a main-memory request port. It keeps a small direct-mapped array of single-word lines. A processor read that finds its word in the array is answered from the array on the next cycle and does not touch memory. A read that misses sends one word read to memory, waits for the answer, fills the line and then passes the word back to the processor.

Every processor write goes to memory unchanged. If the written word is already cached, the cached copy is updated as well. If it is not cached, no line is allocated. Memory gives no response to a write. The cache therefore treats a write as finished when memory accepts the write request, and it shows this to the processor by raising its ready output again. Both ports use a valid/ready request handshake with 32-bit addresses and data. Only memory read data comes back on a one-cycle valid pulse.

Top module: `dmc_cache`

## Requirements
- R1: Reset clears every line's valid flag. After reset, core_req_ready is 1, core_resp_valid is 0 and mem_req_valid is 0, and the first read of any address misses.
- R2: The line is selected by address bits [9:2]. Bits [31:10] form the tag and bits [1:0] are ignored for lookup, so two addresses 1024 bytes apart share a line and evict each other.
- R3: A read hit raises core_resp_valid exactly one cycle after the request is accepted, with the cached word on core_resp_rdata, and issues no memory request.
- R4: A read miss issues exactly one memory read (mem_req_write = 0) at the request address with bits [1:0] forced to 0. It fills the line and raises core_resp_valid in the cycle after mem_resp_valid, carrying the memory data.
- R5: Every accepted processor write issues exactly one memory write (mem_req_write = 1) with the unmodified processor address and data.
- R6: A write whose address is cached also updates the cached word, so a following read of that address hits and returns the written value.
- R7: A write miss allocates nothing. A later read of that address misses, and the word already held in that line stays cached.
- R8: Requests are accepted only while core_req_ready is 1. After a write is accepted, ready stays 0 until memory accepts the write, and it returns to 1 in the cycle after that memory handshake.
- R9: While mem_req_valid is 1 and mem_req_ready is 0, the memory request (valid, write flag, address, data) holds unchanged.
- R10: core_resp_valid is raised only to answer reads. It stays 0 in the cycle after a write is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_req_valid | input | 1 | Processor request present |
| core_req_write | input | 1 | 1 = write, 0 = read |
| core_req_addr | input | 32 | Processor byte address |
| core_req_wdata | input | 32 | Processor write data |
| core_req_ready | output | 1 | Cache can accept a request; returns high when a write is done |
| core_resp_valid | output | 1 | One-cycle read data pulse |
| core_resp_rdata | output | 32 | Read data |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 32 | Memory byte address |
| mem_req_wdata | output | 32 | Memory write data |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_resp_valid | input | 1 | One-cycle memory read data pulse |
| mem_resp_rdata | input | 32 | Memory read data |

## Verification
Two functions can fall in the same cycle: the response pulse of a read hit, and the acceptance of the next processor request, because ready stays high after a hit. The bench keeps core_req_valid high straight after a hit and turns the request into a write. In that cycle it checks that the hit data appears on the response while ready is still high. One cycle later it checks that the response has dropped and ready has fallen for the write. A read that follows then returns the value just written. A stalled memory is also used to hold a write in flight, which shows the request staying stable and ready staying low.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

    localparam int DMC_ADDR_W = 32;
    localparam int DMC_DATA_W = 32;
    localparam int DMC_IDX_W  = 8;
    localparam int DMC_OFF_W  = 2;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RD_REQ  = 2'd1,
        ST_RD_WAIT = 2'd2,
        ST_WR_REQ  = 2'd3
    } dmc_state_e;

endpackage

// File: rtl/dmc_lines.sv
module dmc_lines #(
    parameter int IDX_W  = 8,
    parameter int TAG_W  = 22,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  lk_idx,
    output logic              lk_valid,
    output logic [TAG_W-1:0]  lk_tag,
    output logic [DATA_W-1:0] lk_data,
    input  logic              wr_en,
    input  logic              wr_fill,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int LINES = 1 << IDX_W;

    logic [LINES-1:0]  valid_q;
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [DATA_W-1:0] data_q [LINES];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else if (wr_en && wr_fill) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            data_q[wr_idx] <= wr_data;
            if (wr_fill) begin
                tag_q[wr_idx] <= wr_tag;
            end
        end
    end

    assign lk_valid = valid_q[lk_idx];
    assign lk_tag   = tag_q[lk_idx];
    assign lk_data  = data_q[lk_idx];

    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> (valid_q == '0));

endmodule

// File: rtl/dmc_match.sv
module dmc_match #(
    parameter int TAG_W = 22
) (
    input  logic             line_valid,
    input  logic [TAG_W-1:0] line_tag,
    input  logic [TAG_W-1:0] req_tag,
    output logic             hit
);
    assign hit = line_valid && (line_tag == req_tag);
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
    import dmc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 8,
    parameter int OFF_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              core_req_valid,
    input  logic              core_req_write,
    input  logic [ADDR_W-1:0] core_req_addr,
    input  logic [DATA_W-1:0] core_req_wdata,
    output logic              core_req_ready,
    output logic              core_resp_valid,
    output logic [DATA_W-1:0] core_resp_rdata,
    output logic              mem_req_valid,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_wdata,
    input  logic              mem_req_ready,
    input  logic              mem_resp_valid,
    input  logic [DATA_W-1:0] mem_resp_rdata,
    input  logic              lk_hit,
    input  logic [DATA_W-1:0] lk_data,
    output logic              wr_en,
    output logic              wr_fill,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    typedef struct packed {
        logic              write;
        logic              hit;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } dmc_hold_t;

    dmc_state_e        st_q;
    dmc_hold_t         hold_q;
    logic              resp_v_q;
    logic [DATA_W-1:0] resp_d_q;
    logic              accept;
    logic              fill_now;
    logic              upd_now;

    assign accept   = (st_q == ST_IDLE) && core_req_valid;
    assign fill_now = (st_q == ST_RD_WAIT) && mem_resp_valid;
    assign upd_now  = (st_q == ST_WR_REQ) && mem_req_ready && hold_q.hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            hold_q   <= '0;
            resp_v_q <= 1'b0;
            resp_d_q <= '0;
        end else begin
            resp_v_q <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (core_req_valid) begin
                        hold_q.write <= core_req_write;
                        hold_q.hit   <= lk_hit;
                        hold_q.addr  <= core_req_addr;
                        hold_q.wdata <= core_req_wdata;
                        if (core_req_write) begin
                            st_q <= ST_WR_REQ;
                        end else if (lk_hit) begin
                            resp_v_q <= 1'b1;
                            resp_d_q <= lk_data;
                        end else begin
                            st_q <= ST_RD_REQ;
                        end
                    end
                end
                ST_RD_REQ: begin
                    if (mem_req_ready) st_q <= ST_RD_WAIT;
                end
                ST_RD_WAIT: begin
                    if (mem_resp_valid) begin
                        resp_v_q <= 1'b1;
                        resp_d_q <= mem_resp_rdata;
                        st_q     <= ST_IDLE;
                    end
                end
                ST_WR_REQ: begin
                    if (mem_req_ready) st_q <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign core_req_ready  = (st_q == ST_IDLE);
    assign core_resp_valid = resp_v_q;
    assign core_resp_rdata = resp_d_q;

    assign mem_req_valid = (st_q == ST_RD_REQ) || (st_q == ST_WR_REQ);
    assign mem_req_write = (st_q == ST_WR_REQ);
    assign mem_req_addr  = (st_q == ST_WR_REQ) ? hold_q.addr
                         : {hold_q.addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    assign mem_req_wdata = hold_q.wdata;

    assign wr_en   = fill_now || upd_now;
    assign wr_fill = fill_now;
    assign wr_addr = hold_q.addr;
    assign wr_data = fill_now ? mem_resp_rdata : hold_q.wdata;

    // R9
    mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_write)
            && $stable(mem_req_addr) && $stable(mem_req_wdata)));

    // R8
    wr_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && core_req_write) |=> !core_req_ready);

    // R3
    hit_resp_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && !core_req_write && lk_hit) |=> (core_resp_valid && !mem_req_valid));

    // R4
    fill_resp_chk: assert property (@(posedge clk) disable iff (rst)
        fill_now |=> (core_resp_valid && core_resp_rdata == $past(mem_resp_rdata)));

    // R10
    wr_no_resp_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && core_req_write) |=> !core_resp_valid);

endmodule

// File: rtl/dmc_cache.sv
module dmc_cache
    import dmc_pkg::*;
#(
    parameter int ADDR_W = DMC_ADDR_W,
    parameter int DATA_W = DMC_DATA_W,
    parameter int IDX_W  = DMC_IDX_W,
    parameter int OFF_W  = DMC_OFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              core_req_valid,
    input  logic              core_req_write,
    input  logic [ADDR_W-1:0] core_req_addr,
    input  logic [DATA_W-1:0] core_req_wdata,
    output logic              core_req_ready,
    output logic              core_resp_valid,
    output logic [DATA_W-1:0] core_resp_rdata,
    output logic              mem_req_valid,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_wdata,
    input  logic              mem_req_ready,
    input  logic              mem_resp_valid,
    input  logic [DATA_W-1:0] mem_resp_rdata
);
    localparam int TAG_LO = IDX_W + OFF_W;
    localparam int TAG_W  = ADDR_W - TAG_LO;

    logic              lk_valid;
    logic [TAG_W-1:0]  lk_tag;
    logic [DATA_W-1:0] lk_data;
    logic              lk_hit;
    logic              wr_en;
    logic              wr_fill;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;

    dmc_lines #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_lines (
        .clk      (clk),
        .rst      (rst),
        .lk_idx   (core_req_addr[TAG_LO-1:OFF_W]),
        .lk_valid (lk_valid),
        .lk_tag   (lk_tag),
        .lk_data  (lk_data),
        .wr_en    (wr_en),
        .wr_fill  (wr_fill),
        .wr_idx   (wr_addr[TAG_LO-1:OFF_W]),
        .wr_tag   (wr_addr[ADDR_W-1:TAG_LO]),
        .wr_data  (wr_data)
    );

    dmc_match #(.TAG_W(TAG_W)) u_match (
        .line_valid (lk_valid),
        .line_tag   (lk_tag),
        .req_tag    (core_req_addr[ADDR_W-1:TAG_LO]),
        .hit        (lk_hit)
    );

    dmc_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_ctrl (
        .clk             (clk),
        .rst             (rst),
        .core_req_valid  (core_req_valid),
        .core_req_write  (core_req_write),
        .core_req_addr   (core_req_addr),
        .core_req_wdata  (core_req_wdata),
        .core_req_ready  (core_req_ready),
        .core_resp_valid (core_resp_valid),
        .core_resp_rdata (core_resp_rdata),
        .mem_req_valid   (mem_req_valid),
        .mem_req_write   (mem_req_write),
        .mem_req_addr    (mem_req_addr),
        .mem_req_wdata   (mem_req_wdata),
        .mem_req_ready   (mem_req_ready),
        .mem_resp_valid  (mem_resp_valid),
        .mem_resp_rdata  (mem_resp_rdata),
        .lk_hit          (lk_hit),
        .lk_data         (lk_data),
        .wr_en           (wr_en),
        .wr_fill         (wr_fill),
        .wr_addr         (wr_addr),
        .wr_data         (wr_data)
    );

endmodule

// File: tb/sim_dmc_cache.sv
`timescale 1ns / 1ps
module sim_dmc_cache;
    localparam int CLK_PERIOD = 10;
    localparam int MEM_LAT    = 4;
    localparam int NVEC       = 14;

    // [65] write, [64:33] address, [32:1] write data, [0] expected hit (reads)
    localparam logic [65:0] VECS [NVEC] = '{
        {1'b0, 32'h0000_1000, 32'h0,          1'b0},
        {1'b0, 32'h0000_1000, 32'h0,          1'b1},
        {1'b1, 32'h0000_1000, 32'hDEAD_BEEF,  1'b0},
        {1'b0, 32'h0000_1000, 32'h0,          1'b1},
        {1'b0, 32'h0000_1400, 32'h0,          1'b0},
        {1'b0, 32'h0000_1000, 32'h0,          1'b0},
        {1'b1, 32'h0000_2044, 32'h1234_5678,  1'b0},
        {1'b0, 32'h0000_2044, 32'h0,          1'b0},
        {1'b1, 32'h0000_2444, 32'hCAFE_F00D,  1'b0},
        {1'b0, 32'h0000_2044, 32'h0,          1'b1},
        {1'b0, 32'h0000_2444, 32'h0,          1'b0},
        {1'b0, 32'h0000_2046, 32'h0,          1'b0},
        {1'b0, 32'h0000_FFFC, 32'h0,          1'b0},
        {1'b0, 32'h0000_FFFC, 32'h0,          1'b1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        core_req_valid = 1'b0;
    logic        core_req_write = 1'b0;
    logic [31:0] core_req_addr  = '0;
    logic [31:0] core_req_wdata = '0;
    logic        core_req_ready;
    logic        core_resp_valid;
    logic [31:0] core_resp_rdata;
    logic        mem_req_valid;
    logic        mem_req_write;
    logic [31:0] mem_req_addr;
    logic [31:0] mem_req_wdata;
    logic        mem_req_ready;
    logic        mem_resp_valid;
    logic [31:0] mem_resp_rdata;

    logic [31:0] mem_model [4096];
    logic [31:0] gold      [4096];
    logic        mem_stall = 1'b0;
    logic        m_busy;
    logic [3:0]  m_cnt;
    logic        m_pend_rd;
    logic [11:0] m_pend_idx;
    int          rd_cnt, wr_cnt;
    logic [31:0] last_ra, last_wa, last_wd;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dmc_cache u0 (
        .clk(clk), .rst(rst),
        .core_req_valid(core_req_valid), .core_req_write(core_req_write),
        .core_req_addr(core_req_addr), .core_req_wdata(core_req_wdata),
        .core_req_ready(core_req_ready), .core_resp_valid(core_resp_valid),
        .core_resp_rdata(core_resp_rdata),
        .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_req_ready(mem_req_ready), .mem_resp_valid(mem_resp_valid),
        .mem_resp_rdata(mem_resp_rdata)
    );

    // Fixed-latency memory; busy (not ready) while a request is in flight.
    assign mem_req_ready = !m_busy && !mem_stall;

    always @(posedge clk) begin
        if (rst) begin
            m_busy         <= 1'b0;
            m_cnt          <= '0;
            m_pend_rd      <= 1'b0;
            mem_resp_valid <= 1'b0;
        end else begin
            mem_resp_valid <= 1'b0;
            if (m_busy) begin
                if (m_cnt == 0) begin
                    m_busy <= 1'b0;
                    if (m_pend_rd) begin
                        mem_resp_valid <= 1'b1;
                        mem_resp_rdata <= mem_model[m_pend_idx];
                    end
                end else begin
                    m_cnt <= m_cnt - 1'b1;
                end
            end else if (mem_req_valid && mem_req_ready) begin
                m_busy     <= 1'b1;
                m_cnt      <= 4'(MEM_LAT - 1);
                m_pend_rd  <= !mem_req_write;
                m_pend_idx <= mem_req_addr[13:2];
                if (mem_req_write) begin
                    mem_model[mem_req_addr[13:2]] <= mem_req_wdata;
                    wr_cnt  <= wr_cnt + 1;
                    last_wa <= mem_req_addr;
                    last_wd <= mem_req_wdata;
                end else begin
                    rd_cnt  <= rd_cnt + 1;
                    last_ra <= mem_req_addr;
                end
            end
        end
    end

    function automatic logic [31:0] pat(int i);
        return 32'h5A00_0000 ^ (i * 32'h0001_0003);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_read(logic [31:0] addr, output logic [31:0] data, output int lat);
        core_req_valid = 1'b1;
        core_req_write = 1'b0;
        core_req_addr  = addr;
        while (!core_req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        core_req_valid = 1'b0;
        lat = 1;
        while (!core_resp_valid && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        data = core_resp_rdata;
    endtask

    task automatic do_write(logic [31:0] addr, logic [31:0] data, output int lat);
        core_req_valid = 1'b1;
        core_req_write = 1'b1;
        core_req_addr  = addr;
        core_req_wdata = data;
        while (!core_req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        core_req_valid = 1'b0;
        lat = 1;
        while (!core_req_ready && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        gold[addr[13:2]] = data;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int          lat;
        int          r0, w0;
        for (int i = 0; i < 4096; i++) begin
            mem_model[i] = pat(i);
            gold[i]      = pat(i);
        end
        rd_cnt = 0;
        wr_cnt = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: state right after reset
        chk("R1 ready", 32'(core_req_ready), 32'd1);
        chk("R1 resp_valid", 32'(core_resp_valid), 32'd0);
        chk("R1 mem_req_valid", 32'(mem_req_valid), 32'd0);

        // Table walk: R2 R3 R4 R5 R6 R7
        for (int v = 0; v < NVEC; v++) begin
            logic        w;
            logic [31:0] a, wd;
            logic        eh;
            {w, a, wd, eh} = VECS[v];
            if (w) begin
                w0 = wr_cnt;
                do_write(a, wd, lat);
                chk("R5 write count", 32'(wr_cnt - w0), 32'd1);
                chk("R5 write addr", last_wa, a);
                chk("R5 write data", last_wd, wd);
            end else begin
                r0 = rd_cnt;
                do_read(a, d, lat);
                chk("R6 R7 read data", d, gold[a[13:2]]);
                chk(eh ? "R3 no mem read" : "R2 R4 R7 one mem read",
                    32'(rd_cnt - r0), eh ? 32'd0 : 32'd1);
                if (eh) chk("R3 hit latency", 32'(lat), 32'd1);
                else    chk("R4 aligned mem addr", last_ra, {a[31:2], 2'b00});
            end
        end

        // R8 R9: write held in flight by a stalled memory
        repeat (6) @(negedge clk);
        mem_stall = 1'b1;
        core_req_valid = 1'b1;
        core_req_write = 1'b1;
        core_req_addr  = 32'h0000_1000;
        core_req_wdata = 32'h0BAD_F00D;
        while (!core_req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        core_req_valid = 1'b0;
        w0 = wr_cnt;
        for (int k = 0; k < 5; k++) begin
            chk("R8 ready low in write", 32'(core_req_ready), 32'd0);
            chk("R9 mem req held", {mem_req_valid, mem_req_write, 30'd0}, {2'b11, 30'd0});
            chk("R9 mem addr held", mem_req_addr, 32'h0000_1000);
            @(negedge clk);
        end
        mem_stall = 1'b0;
        @(negedge clk);
        chk("R8 ready after mem accept", 32'(core_req_ready), 32'd1);
        chk("R5 stalled write count", 32'(wr_cnt - w0), 32'd1);
        gold[12'h400] = 32'h0BAD_F00D;

        // Same cycle: hit response while the next request (a write) is accepted
        core_req_valid = 1'b1;
        core_req_write = 1'b0;
        core_req_addr  = 32'h0000_1000;
        @(posedge clk);
        @(negedge clk);
        core_req_write = 1'b1;
        core_req_wdata = 32'h600D_CAFE;
        chk("R3 b2b resp_valid", 32'(core_resp_valid), 32'd1);
        chk("R6 b2b hit data", core_resp_rdata, 32'h0BAD_F00D);
        chk("R8 b2b ready still high", 32'(core_req_ready), 32'd1);
        @(posedge clk);
        @(negedge clk);
        core_req_valid = 1'b0;
        chk("R10 no resp after write", 32'(core_resp_valid), 32'd0);
        chk("R8 ready low after write", 32'(core_req_ready), 32'd0);
        while (!core_req_ready) @(negedge clk);
        gold[12'h400] = 32'h600D_CAFE;
        r0 = rd_cnt;
        do_read(32'h0000_1000, d, lat);
        chk("R6 read after b2b write", d, 32'h600D_CAFE);
        chk("R3 hit latency after write", 32'(lat), 32'd1);
        chk("R3 no mem read on hit", 32'(rd_cnt - r0), 32'd0);

        // R1: reset in mid-run invalidates lines
        repeat (8) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 ready after reset", 32'(core_req_ready), 32'd1);
        chk("R1 mem idle after reset", 32'(mem_req_valid), 32'd0);
        r0 = rd_cnt;
        do_read(32'h0000_1000, d, lat);
        chk("R1 miss after reset", 32'(rd_cnt - r0), 32'd1);
        chk("R1 data after reset", d, gold[12'h400]);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule